// File: doc/BRIEF.md
# Counted Loop Branch Unit

This unit resolves the branch outcome of counted-loop instructions and of the jump that tests whether the count is zero. Each cycle it can accept one instruction. The instruction carries its kind, the current 32-bit iteration count, the zero flag, the address of the following instruction and a signed 8-bit displacement. One clock later it returns the new count, whether the branch is taken, and the address to fetch next.

The three loop kinds first reduce the count by one and then test the reduced value. Two of them also require the zero flag to be set or clear. The count-zero jump tests the incoming count and leaves it alone. No form produces or alters a flag. A kind code outside the four defined codes yields no result. Fetch logic uses the registered next address and the taken bit to steer the front end, and writes the returned count back into its register file.

Top module: `loop_branch_unit`

## Requirements
- R1: Kind code 0 (plain loop) returns the incoming count minus one and is taken exactly when that new count is nonzero.
- R2: Kind code 1 (loop while equal) returns the count minus one and is taken only when the zero flag is 1 and the new count is nonzero.
- R3: Kind code 2 (loop while not equal) returns the count minus one and is taken only when the zero flag is 0 and the new count is nonzero.
- R4: Kind code 3 (jump on zero count) is taken exactly when the incoming count is zero, and it returns the count unchanged.
- R5: When the branch is taken, the next address is the incoming address plus the displacement sign-extended to 32 bits, modulo 2^32. This covers displacements from -128 to +127.
- R6: When the branch is not taken, the next address equals the incoming address.
- R7: A loop kind that starts with a count of zero wraps the count to all ones and is taken.
- R8: For an accepted input, `res_valid` is high for exactly the following cycle and carries that input's results. With no valid input, `res_valid` is low on the next cycle.
- R9: Kind codes 4 to 7 are unrecognised. They raise no `res_valid`, and they leave `res_count`, `res_taken` and `res_next_ip` unchanged.
- R10: After reset, `res_valid`, `res_taken`, `res_count` and `res_next_ip` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Instruction present this cycle |
| op_kind | input | 3 | Kind code: 0 loop, 1 loop while equal, 2 loop while not equal, 3 jump on zero count |
| op_count | input | 32 | Current iteration count |
| op_zf | input | 1 | Current zero flag |
| op_ip | input | 32 | Address of the following instruction |
| op_disp | input | 8 | Signed branch displacement |
| res_valid | output | 1 | Result strobe, one cycle after an accepted input |
| res_count | output | 32 | Updated count |
| res_taken | output | 1 | Branch taken |
| res_next_ip | output | 32 | Next fetch address |

## Verification
Every result appears exactly one clock after the edge that samples its input, because only one register stage separates input and output. The bench drives each instruction on a falling edge. On the next falling edge it compares all four outputs with a behavioural model, so it samples one full cycle after the input. On cycles with no valid result, the model keeps the last result values, and the bench checks the strobe and the held fields against them. This is how ignored kind codes are observed at the ports.

// File: rtl/loop_br_pkg.sv
package loop_br_pkg;

  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    BR_LOOP      = 3'd0,
    BR_LOOP_Z    = 3'd1,
    BR_LOOP_NZ   = 3'd2,
    BR_CNT_ZERO  = 3'd3
  } br_kind_e;

  typedef struct packed {
    logic known;      // kind code is one of the four defined codes
    logic dec;        // count is decremented before the test
    logic zf_gate;    // zero flag takes part in the decision
    logic zf_want;    // required zero flag value when gated
    logic zero_test;  // taken on a zero incoming count
  } br_ctrl_t;

endpackage

// File: rtl/lb_decode.sv
module lb_decode
  import loop_br_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  output br_ctrl_t          ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (kind_i)
      BR_LOOP: begin
        ctrl_o.known = 1'b1;
        ctrl_o.dec   = 1'b1;
      end
      BR_LOOP_Z: begin
        ctrl_o.known   = 1'b1;
        ctrl_o.dec     = 1'b1;
        ctrl_o.zf_gate = 1'b1;
        ctrl_o.zf_want = 1'b1;
      end
      BR_LOOP_NZ: begin
        ctrl_o.known   = 1'b1;
        ctrl_o.dec     = 1'b1;
        ctrl_o.zf_gate = 1'b1;
        ctrl_o.zf_want = 1'b0;
      end
      BR_CNT_ZERO: begin
        ctrl_o.known     = 1'b1;
        ctrl_o.zero_test = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/lb_count_cond.sv
module lb_count_cond
  import loop_br_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  br_ctrl_t          ctrl_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              zf_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              take_o
);

  logic [CNT_W-1:0] count_dec;
  logic             new_nz;
  logic             in_zero;
  logic             zf_ok;

  // Decrement wraps naturally: zero becomes all ones.
  assign count_dec = count_i - CNT_W'(1);
  assign count_o   = ctrl_i.dec ? count_dec : count_i;
  assign new_nz    = |count_dec;
  assign in_zero   = ~|count_i;
  assign zf_ok     = ~ctrl_i.zf_gate | (zf_i == ctrl_i.zf_want);

  always_comb begin
    if (!ctrl_i.known) begin
      take_o = 1'b0;
    end else if (ctrl_i.zero_test) begin
      take_o = in_zero;
    end else begin
      take_o = new_nz & zf_ok;
    end
  end

endmodule

// File: rtl/lb_target.sv
module lb_target #(
  parameter int unsigned IP_W   = 32,
  parameter int unsigned DISP_W = 8
) (
  input  logic [IP_W-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              take_i,
  output logic [IP_W-1:0]   next_ip_o
);

  localparam int unsigned EXT_W = IP_W - DISP_W;

  logic [IP_W-1:0] disp_ext;
  logic [IP_W-1:0] target;

  assign disp_ext  = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign target    = ip_i + disp_ext;
  assign next_ip_o = take_i ? target : ip_i;

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import loop_br_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned IP_W   = 32,
  parameter int unsigned DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [KIND_W-1:0] op_kind,
  input  logic [CNT_W-1:0]  op_count,
  input  logic              op_zf,
  input  logic [IP_W-1:0]   op_ip,
  input  logic [DISP_W-1:0] op_disp,
  output logic              res_valid,
  output logic [CNT_W-1:0]  res_count,
  output logic              res_taken,
  output logic [IP_W-1:0]   res_next_ip
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe[1];

  // Combinational resolution.
  br_ctrl_t         ctrl;
  logic [CNT_W-1:0] count_new;
  logic             take_new;
  logic [IP_W-1:0]  ip_new;
  logic             accept;

  lb_decode u_dec (
    .kind_i (op_kind),
    .ctrl_o (ctrl)
  );

  lb_count_cond #(.CNT_W(CNT_W)) u_cond (
    .ctrl_i  (ctrl),
    .count_i (op_count),
    .zf_i    (op_zf),
    .count_o (count_new),
    .take_o  (take_new)
  );

  lb_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
    .ip_i      (op_ip),
    .disp_i    (op_disp),
    .take_i    (take_new),
    .next_ip_o (ip_new)
  );

  assign accept = op_valid & ctrl.known;

  // Next state.
  logic             valid_d;
  logic [CNT_W-1:0] count_d;
  logic             taken_d;
  logic [IP_W-1:0]  ip_d;

  always_comb begin
    valid_d = accept;
    count_d = res_count;
    taken_d = res_taken;
    ip_d    = res_next_ip;
    if (accept) begin
      count_d = count_new;
      taken_d = take_new;
      ip_d    = ip_new;
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_valid   <= 1'b0;
      res_count   <= '0;
      res_taken   <= 1'b0;
      res_next_ip <= '0;
    end else begin
      res_valid   <= valid_d;
      res_count   <= count_d;
      res_taken   <= taken_d;
      res_next_ip <= ip_d;
    end
  end

endmodule

// File: rtl/lbu_checker.sv
module lbu_checker
  import loop_br_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned IP_W   = 32,
  parameter int unsigned DISP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [KIND_W-1:0] op_kind,
  input logic [CNT_W-1:0]  op_count,
  input logic              op_zf,
  input logic [IP_W-1:0]   op_ip,
  input logic [DISP_W-1:0] op_disp,
  input logic              res_valid,
  input logic [CNT_W-1:0]  res_count,
  input logic              res_taken,
  input logic [IP_W-1:0]   res_next_ip
);

  logic good_in;
  assign good_in = op_valid && (op_kind <= KIND_W'(BR_CNT_ZERO));

  a_r8_result_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    good_in |=> res_valid);

  a_r9_no_result_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    !good_in |=> !res_valid);

  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !good_in |=> ($stable(res_count) && $stable(res_taken) && $stable(res_next_ip)));

  a_r1_loop_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == KIND_W'(BR_LOOP)) |=>
      (res_count == CNT_W'($past(op_count) - CNT_W'(1))));

  a_r4_zero_jump_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == KIND_W'(BR_CNT_ZERO)) |=>
      (res_count == $past(op_count) && res_taken == ($past(op_count) == '0)));

  a_r6_fallthrough_ip: assert property (@(posedge clk) disable iff (!rst_n)
    good_in |=> (res_taken || res_next_ip == $past(op_ip)));

  a_r7_wrap_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == KIND_W'(BR_LOOP) && op_count == '0) |=> res_taken);

  logic unused_ok;
  assign unused_ok = ^{op_zf, op_disp};

endmodule

bind loop_branch_unit lbu_checker #(
  .CNT_W  (CNT_W),
  .IP_W   (IP_W),
  .DISP_W (DISP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .op_valid    (op_valid),
  .op_kind     (op_kind),
  .op_count    (op_count),
  .op_zf       (op_zf),
  .op_ip       (op_ip),
  .op_disp     (op_disp),
  .res_valid   (res_valid),
  .res_count   (res_count),
  .res_taken   (res_taken),
  .res_next_ip (res_next_ip)
);

// File: tb/sim_loop_branch_unit.sv
module sim_loop_branch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [31:0] op_count;
  logic        op_zf;
  logic [31:0] op_ip;
  logic [7:0]  op_disp;
  logic        res_valid;
  logic [31:0] res_count;
  logic        res_taken;
  logic [31:0] res_next_ip;

  int total;
  int bad;
  bit done;

  // Behavioural model state: the result expected at the next sample.
  bit          m_valid;
  logic [31:0] m_count;
  bit          m_taken;
  logic [31:0] m_ip;
  string       m_tag;

  loop_branch_unit u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .op_count    (op_count),
    .op_zf       (op_zf),
    .op_ip       (op_ip),
    .op_disp     (op_disp),
    .res_valid   (res_valid),
    .res_count   (res_count),
    .res_taken   (res_taken),
    .res_next_ip (res_next_ip)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, "valid", longint'(res_valid), longint'(m_valid));
    chk(m_tag, "count", longint'(res_count), longint'(m_count));
    chk(m_tag, "taken", longint'(res_taken), longint'(m_taken));
    chk(m_tag, "next_ip", longint'(res_next_ip), longint'(m_ip));
  endtask

  // One instruction slot: compare previous result, then drive and model.
  task automatic step(input string tag, input bit v, input logic [2:0] k,
                      input logic [31:0] c, input bit z,
                      input logic [31:0] ip, input logic [7:0] d);
    longint cnt_after;
    longint tgt;
    bit     tk;
    @(negedge clk);
    compare_all();
    op_valid = v; op_kind = k; op_count = c; op_zf = z; op_ip = ip; op_disp = d;
    m_tag = tag;
    if (v && k < 3'd4) begin
      if (k == 3'd3) begin
        cnt_after = longint'(c);
        tk = (c == 0);
      end else begin
        cnt_after = (longint'(c) + 64'hFFFF_FFFF) % 64'h1_0000_0000;
        tk = (cnt_after != 0);
        if (k == 3'd1) tk = tk && z;
        if (k == 3'd2) tk = tk && !z;
      end
      tgt = (longint'(ip) + longint'($signed(d)) + 64'h1_0000_0000) % 64'h1_0000_0000;
      m_valid = 1'b1;
      m_count = cnt_after[31:0];
      m_taken = tk;
      m_ip    = tk ? tgt[31:0] : ip;
    end else begin
      m_valid = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    total = 0; bad = 0; done = 0;
    op_valid = 0; op_kind = 0; op_count = 0; op_zf = 0; op_ip = 0; op_disp = 0;
    m_valid = 0; m_count = 0; m_taken = 0; m_ip = 0; m_tag = "R10";
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R10: reset state observed before any stimulus
    step("R10", 0, 3'd0, 32'd0, 0, 32'd0, 8'd0);

    step("R1", 1, 3'd0, 32'd5, 0, 32'h0000_1000, 8'hF0);
    step("R1", 1, 3'd0, 32'd1, 1, 32'h0000_2000, 8'h10);          // new count 0, not taken
    step("R6", 1, 3'd0, 32'd1, 0, 32'h1234_5678, 8'h7F);
    step("R7", 1, 3'd0, 32'd0, 0, 32'h0000_3000, 8'hFE);          // wraps to all ones
    step("R7", 1, 3'd1, 32'd0, 1, 32'h0000_3100, 8'h02);
    step("R2", 1, 3'd1, 32'd9, 1, 32'h0000_4000, 8'h20);
    step("R2", 1, 3'd1, 32'd9, 0, 32'h0000_4000, 8'h20);
    step("R2", 1, 3'd1, 32'd1, 1, 32'h0000_4000, 8'h20);
    step("R3", 1, 3'd2, 32'd9, 0, 32'h0000_5000, 8'hE0);
    step("R3", 1, 3'd2, 32'd9, 1, 32'h0000_5000, 8'hE0);
    step("R3", 1, 3'd2, 32'd1, 0, 32'h0000_5000, 8'hE0);
    step("R4", 1, 3'd3, 32'd0, 0, 32'h0000_6000, 8'h40);
    step("R4", 1, 3'd3, 32'd7, 1, 32'h0000_6000, 8'h40);
    step("R4", 1, 3'd3, 32'hFFFF_FFFF, 0, 32'h0000_6000, 8'h40);
    step("R5", 1, 3'd0, 32'd3, 0, 32'h0000_0100, 8'h80);          // -128
    step("R5", 1, 3'd0, 32'd3, 0, 32'h0000_0100, 8'h7F);          // +127
    step("R5", 1, 3'd0, 32'd3, 0, 32'hFFFF_FFC0, 8'h7F);          // wraps up
    step("R5", 1, 3'd3, 32'd0, 0, 32'h0000_0010, 8'h80);          // wraps down
    step("R9", 1, 3'd4, 32'd0, 0, 32'hAAAA_0000, 8'h11);
    step("R9", 1, 3'd5, 32'd0, 1, 32'hBBBB_0000, 8'h22);
    step("R9", 1, 3'd6, 32'd5, 0, 32'hCCCC_0000, 8'h33);
    step("R9", 1, 3'd7, 32'd0, 1, 32'hDDDD_0000, 8'h44);
    step("R8", 0, 3'd0, 32'd4, 0, 32'hEEEE_0000, 8'h55);          // no valid input
    step("R8", 1, 3'd2, 32'd4, 0, 32'h0000_7000, 8'h08);
    step("R8", 1, 3'd2, 32'd3, 0, 32'h0000_7008, 8'h08);          // back to back

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] k;
      logic [31:0] c;
      string tg;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      k = lfsr[2:0];
      c = (lfsr[5:4] == 2'b00) ? {30'd0, lfsr[7:6]} : lfsr;
      case (k)
        3'd0: tg = "R1";
        3'd1: tg = "R2";
        3'd2: tg = "R3";
        3'd3: tg = "R4";
        default: tg = "R9";
      endcase
      step(tg, lfsr[9] | lfsr[10], k, c, lfsr[11], {lfsr[15:0], lfsr[31:16]}, lfsr[23:16]);
    end
    step("R8", 0, 3'd0, 32'd0, 0, 32'd0, 8'd0);
    @(negedge clk);
    compare_all();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule